// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking

This block decides which of seven masters may drive a shared parallel bus. Each master has its own active-low request line and receives its own active-low grant line. The arbiter watches the bus framing and initiator-ready strobes to tell when the bus is free. It moves ownership only while the bus is idle, and it picks among competing requesters in a rotating order so that no master is starved.

While nobody else asks for the bus, the current owner keeps its grant even after it lets go of its request. It can then start another transaction by asserting the framing strobe without asking again. One agent, the bridge, picked by a parameter, is exempt from this rule. Once the bridge has stopped requesting and the bus is idle with no other request pending, its grant is taken away. The bus then parks on a default agent, also picked by a parameter.

The grant lines come straight from registers. A change of owner always passes through at least one clock in which no grant is asserted.

Top module: `bus_rr_arbiter`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) deasserts every grant and sets the rotation pointer to index 0, so the first contested grant after reset goes to the lowest requesting index.
- R2: At most one bit of gnt_n is low in any cycle.
- R3: A grant becomes asserted only at an edge where the bus was idle, meaning frame_n and irdy_n were both high.
- R4: A grant never moves directly from one master to another. Between two different owners there is at least one cycle with all of gnt_n high.
- R5: With no grant asserted and the bus idle, the grant goes to the first requester found by scanning from the pointer upward, wrapping from index 6 to index 0. The pointer then moves to the winner's index plus one, modulo 7.
- R6: An owner that is not the bridge keeps its grant while no other master requests, whether or not it still requests itself.
- R7: When any master other than the owner requests, the owner's grant is removed at the next edge, whatever the bus state.
- R8: The bridge (index 5 by default) loses its grant at an edge where it does not request, no other master requests, and the bus is idle. While the bus is busy it keeps the grant.
- R9: While the bus is busy (frame_n or irdy_n low), no grant is newly asserted, so a master whose grant was removed mid-transaction can finish.
- R10: An owner holding a parked grant may drive frame_n and irdy_n low without requesting, and it keeps its grant while doing so.
- R11: With no grant asserted, the bus idle and no request pending, the grant parks on the default agent (index 0 by default) at the next edge. The pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 7 | Per-master bus request, active low, bit i for master i |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| gnt_n | output | 7 | Per-master bus grant, active low, bit i for master i |

## Verification
The assertions assume that req_n, frame_n and irdy_n are synchronous to clk and never unknown at a rising edge. They also assume that no sampled value is in flux at that edge. They take no protocol from the masters for granted: a master may request, drop a request or drive the strobes in any cycle, including without a grant. The stimulus changes every input only on the falling clock edge. It uses every request pattern, directed busy and idle sequences around preemption and bridge release, and unconstrained random traffic, so the checks hold for arbitrary master behaviour.

// File: rtl/arb_rr_pkg.sv
package arb_rr_pkg;

  // Modular step used for pointer rotation and the rotated scan.
  function automatic int wrap_add(int base, int step, int modulus);
    return (base + step) % modulus;
  endfunction

  // Bus is free when neither strobe is driven low.
  function automatic logic bus_free(logic frame_n, logic irdy_n);
    return frame_n & irdy_n;
  endfunction

endpackage

// File: rtl/arb_bus_monitor.sv
module arb_bus_monitor (
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle
);
  import arb_rr_pkg::*;

  always_comb idle = bus_free(frame_n, irdy_n);

endmodule

// File: rtl/arb_rr_picker.sv
module arb_rr_picker #(
  parameter int N  = 7,
  parameter int PW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] winner
);
  import arb_rr_pkg::*;

  // rot[k] is the request of the master k places after the pointer
  logic [N-1:0] rot;

  for (genvar k = 0; k < N; k++) begin : g_rot
    logic [PW-1:0] slot;
    assign slot   = PW'(wrap_add(int'(ptr), k, N));
    assign rot[k] = req[slot];
  end

  // lowest rotated position wins
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found  = 1'b1;
        winner = PW'(wrap_add(int'(ptr), k, N));
      end
    end
  end

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
  parameter int N           = 7,
  parameter int PW          = 3,
  parameter int BRIDGE_IDX  = 5,
  parameter int DEFAULT_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          idle,
  input  logic          found,
  input  logic [PW-1:0] winner,
  output logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt_oh
);
  import arb_rr_pkg::*;

  logic          held_q;
  logic [PW-1:0] owner_q;
  logic [PW-1:0] ptr_q;
  logic [N-1:0]  owner_oh;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign owner_oh[i] = (owner_q == PW'(i));
  end

  assign gnt_oh = held_q ? owner_oh : '0;
  assign ptr    = ptr_q;

  // named internal events
  logic rival_req;
  logic bridge_owner;
  logic ev_revoke;
  logic ev_grant;
  logic ev_park;

  assign rival_req    = |(req & ~owner_oh);
  assign bridge_owner = (owner_q == PW'(BRIDGE_IDX));
  assign ev_revoke    = held_q && (rival_req || (bridge_owner && !req[owner_q] && idle));
  assign ev_grant     = !held_q && idle && found;
  assign ev_park      = !held_q && idle && !found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (ev_revoke) begin
      held_q  <= 1'b0;
    end else if (ev_grant) begin
      held_q  <= 1'b1;
      owner_q <= winner;
      ptr_q   <= PW'(wrap_add(int'(winner), 1, N));
    end else if (ev_park) begin
      held_q  <= 1'b1;
      owner_q <= PW'(DEFAULT_IDX);
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh));

  // R3
  grant_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_oh) && !(|$past(gnt_oh))) |-> $past(idle));

  // R4
  handoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_oh) && (|$past(gnt_oh))) |-> (gnt_oh == $past(gnt_oh)));

  // R6
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_oh) && !(|(req & ~gnt_oh)) && !gnt_oh[BRIDGE_IDX]) |=> $stable(gnt_oh));

  // R7
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_oh) && (|(req & ~gnt_oh))) |=> !(|gnt_oh));

  // R8
  bridge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_oh[BRIDGE_IDX] && !(|req) && idle) |=> !(|gnt_oh));

  // R9
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|gnt_oh) && !idle) |=> !(|gnt_oh));

  // R11
  default_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|gnt_oh) && idle && !(|req)) |=> gnt_oh[DEFAULT_IDX]);

endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter #(
  parameter int NUM_MASTERS = 7,
  parameter int BRIDGE_IDX  = 5,
  parameter int DEFAULT_IDX = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_n,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  output logic [NUM_MASTERS-1:0] gnt_n
);
  localparam int PW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [NUM_MASTERS-1:0] req;
  logic [NUM_MASTERS-1:0] gnt_oh;
  logic                   idle;
  logic                   found;
  logic [PW-1:0]          winner;
  logic [PW-1:0]          ptr;

  assign req   = ~req_n;
  assign gnt_n = ~gnt_oh;

  arb_bus_monitor u_mon (
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .idle    (idle)
  );

  arb_rr_picker #(.N(NUM_MASTERS), .PW(PW)) u_pick (
    .req    (req),
    .ptr    (ptr),
    .found  (found),
    .winner (winner)
  );

  arb_grant_ctrl #(
    .N(NUM_MASTERS), .PW(PW), .BRIDGE_IDX(BRIDGE_IDX), .DEFAULT_IDX(DEFAULT_IDX)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .idle   (idle),
    .found  (found),
    .winner (winner),
    .ptr    (ptr),
    .gnt_oh (gnt_oh)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (gnt_n == '1));

endmodule

// File: tb/bus_rr_arbiter_test.sv
module bus_rr_arbiter_test;
  localparam int N   = 7;
  localparam int BR  = 5;
  localparam int DEF = 0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  always #10 clk = ~clk;   // 50 MHz

  bus_rr_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state kept from the requirements
  bit       m_held = 0;
  int       m_owner = 0;
  int       m_ptr = 0;
  logic [N-1:0] prev_gnt = '0;
  bit       prev_idle = 1;

  function automatic logic [N-1:0] expect_oh();
    logic [N-1:0] v = '0;
    if (m_held) v[m_owner] = 1'b1;
    return v;
  endfunction

  task automatic model_edge(input logic [N-1:0] r, input bit idle_now, input bit rst);
    if (rst) begin
      m_held = 0; m_ptr = 0;
    end else if (m_held) begin
      bit rivals = 0;
      for (int i = 0; i < N; i++) if (r[i] && i != m_owner) rivals = 1;
      if (rivals) m_held = 0;
      else if (m_owner == BR && !r[m_owner] && idle_now) m_held = 0;
    end else if (idle_now) begin
      int pick = -1;
      for (int k = 0; k < N; k++) begin
        int cand = (m_ptr + k) % N;
        if (pick < 0 && r[cand]) pick = cand;
      end
      if (pick >= 0) begin
        m_held = 1; m_owner = pick; m_ptr = (pick + 1) % N;
      end else begin
        m_held = 1; m_owner = DEF;
      end
    end
  endtask

  // called at a falling edge: drive, let one rising edge pass, check
  task automatic apply(input logic [N-1:0] r, input bit fr_n, input bit ir_n,
                       input bit rst, input string tag);
    logic [N-1:0] got;
    logic [N-1:0] exp;
    bit idle_now;
    req_n = ~r; frame_n = fr_n; irdy_n = ir_n; rst_n = ~rst;
    idle_now = fr_n & ir_n;
    @(posedge clk);
    model_edge(r, idle_now, rst);
    @(negedge clk);
    got = ~gnt_n;
    exp = expect_oh();
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: grant got %b expected %b", tag, got, exp);
    end
    vectors++;
    if ($countones(got) > 1) begin
      errors++;
      $display("FAIL R2: grant got %b expected at most one bit", got);
    end
    vectors++;
    if ((|got) && (|prev_gnt) && got != prev_gnt) begin
      errors++;
      $display("FAIL R4: grant got %b expected gap after %b", got, prev_gnt);
    end
    vectors++;
    if (!rst && (|got) && !(|prev_gnt) && !idle_now) begin
      errors++;
      $display("FAIL R3: grant got %b expected none on busy bus", got);
    end
    prev_gnt = got;
    prev_idle = idle_now;
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 3; i++) apply('0, 1, 1, 1, "R1");
    // R1: pointer at 0, so full contention picks index 0
    apply('1, 1, 1, 0, "R1");
    apply('0, 1, 1, 0, "R7");
    apply('0, 1, 1, 0, "R5");
    // R11 park on default from empty state
    for (int i = 0; i < 2; i++) apply('0, 1, 1, 0, "R11");
    // R5 sweep every request pattern, R6/R8 on release
    for (int p = 1; p < (1 << N); p++) begin
      for (int c = 0; c < 3; c++) apply(N'(p), 1, 1, 0, "R5");
      for (int c = 0; c < 2; c++) apply('0, 1, 1, 0, "R6");
    end
    // directed: parked owner runs a transaction without request
    apply('0, 1, 1, 0, "R11");
    for (int c = 0; c < 3; c++) apply(N'(1 << 2), 1, 1, 0, "R5");
    for (int c = 0; c < 3; c++) apply('0, 0, 0, 0, "R10");
    apply(N'(1 << 4), 0, 0, 0, "R7");
    for (int c = 0; c < 3; c++) apply(N'(1 << 4), 0, 1, 0, "R9");
    apply(N'(1 << 4), 1, 0, 0, "R9");
    apply(N'(1 << 4), 1, 1, 0, "R9");
    apply(N'(1 << 4), 1, 1, 0, "R6");
    // bridge: win, drop request while busy, then release on idle
    apply(N'(1 << BR), 1, 1, 0, "R7");
    apply(N'(1 << BR), 1, 1, 0, "R5");
    for (int c = 0; c < 2; c++) apply('0, 0, 1, 0, "R8");
    apply('0, 1, 1, 0, "R8");
    apply('0, 1, 1, 0, "R11");
    apply('0, 1, 1, 0, "R6");
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r = '0;
      for (int i = 0; i < N; i++) r[i] = ($urandom_range(0, 5) == 0);
      apply(r, ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0),
            ($urandom_range(0, 400) == 0), "R5");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule